// File: doc/BRIEF.md
# Timer Event Flag Register

This block keeps the pending-event flags for one 16-bit timer and one 8-bit timer in a single byte that software can read. Each flag is set by a hardware event: an overflow, a compare match, a capture, or the counter reaching TOP while the capture register serves as TOP. Software clears a flag by writing a one to its bit. The flag also clears when the matching interrupt vector is taken, which the interrupt controller signals with a one-cycle acknowledge for that source.

For the two compare channels of the 16-bit timer, the block watches the counter value and the compare register values itself. A flag is raised on the timer tick that follows the matching tick, not on the matching tick. Forced-compare strobes act like a match elsewhere in the timer, but here they are deliberately kept away from the flags. Each interrupt request output is its flag ANDed with an enable bit from a mask input.

Top module: `timer_flag_reg`

## Requirements
- R1: After reset every bit of `flagsOut` is 0. The byte layout is fixed: bit 7 is the 16-bit overflow, bit 6 is compare A, bit 5 is compare B, bit 3 is capture, bit 1 is the 8-bit overflow and bit 0 is the 8-bit compare match.
- R2: Bits 4 and 2 of `flagsOut` always read 0, and a write of ones to them has no effect.
- R3: When `tick` is high and `count` equals `cmpA` (or `cmpB`), the compare A flag (bit 6) or compare B flag (bit 5) is set at the clock edge of the next cycle in which `tick` is high. It stays 0 until then.
- R4: `forceA` and `forceB` never set the compare flags.
- R5: A high `captureEvt` sets bit 3 at the next clock edge, whatever the value of `tick`.
- R6: When `tick`, `capIsTop` and `topReached` are all high, bit 3 is set at the next edge. With `capIsTop` low, `topReached` has no effect.
- R7: `ovf16Evt`, `ovf8Evt` and `cmp8Evt` set bits 7, 1 and 0 only in a cycle where `tick` is high. In other cycles they are ignored.
- R8: A cycle with `wrEn` high clears every flag whose bit in `wrData` is 1. A bit written as 0 leaves its flag unchanged.
- R9: `ack[i]` clears one source's flag. The source order is: 0 is the 8-bit compare, 1 the 8-bit overflow, 2 capture, 3 compare B, 4 compare A, 5 the 16-bit overflow.
- R10: If a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R11: `irq[i]` equals flag i AND `irqEnable[i]` in the source order of R9. It responds combinationally to the flag and to the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock-enable tick |
| count | input | 16 | 16-bit counter value |
| cmpA | input | 16 | Compare register A value |
| cmpB | input | 16 | Compare register B value |
| forceA | input | 1 | Forced-compare strobe, channel A |
| forceB | input | 1 | Forced-compare strobe, channel B |
| captureEvt | input | 1 | Capture event on the capture input |
| topReached | input | 1 | Counter is at TOP |
| capIsTop | input | 1 | Mode bit: the capture register is used as TOP |
| ovf16Evt | input | 1 | 16-bit timer overflow event |
| ovf8Evt | input | 1 | 8-bit timer overflow event |
| cmp8Evt | input | 1 | 8-bit timer compare match event |
| wrEn | input | 1 | CPU write strobe |
| wrData | input | 8 | CPU write data (a one clears the flag) |
| ack | input | 6 | Per-source vector acknowledge |
| irqEnable | input | 6 | Per-source interrupt enable |
| flagsOut | output | 8 | Flag byte as read by the CPU |
| irq | output | 6 | Masked interrupt requests |

## Verification
Most results become visible one edge after their cause: the overflow, capture and TOP sets, and the write-one and acknowledge clears. A compare flag is different: it appears at the edge of the second qualifying tick, counted from the matching tick, however many idle cycles lie between the two. The interrupt requests follow the flags and the enables within the same cycle. The bench changes inputs 1 ns after a rising edge and updates its expected state at that edge. It compares the flag byte and the requests 1 ns after the following edge, so each result is sampled in the cycle it is due. Directed sequences put idle cycles between a match and the next tick. Constrained random traffic keeps the counter and compare values in a narrow range so that matches occur often.

// File: rtl/timer_flag_pkg.sv
package timer_flag_pkg;
  localparam int NumSrc = 6;
  localparam int ByteW  = 8;

  localparam int SrcCmp8  = 0;
  localparam int SrcOvf8  = 1;
  localparam int SrcCap   = 2;
  localparam int SrcCmpB  = 3;
  localparam int SrcCmpA  = 4;
  localparam int SrcOvf16 = 5;

  typedef struct packed {
    logic [NumSrc-1:0] setVec;
    logic [NumSrc-1:0] clrVec;
  } flagStrobe_t;

  // bit position of each source inside the CPU-visible byte
  function automatic int flagPos(input int src);
    case (src)
      SrcCmp8:  return 0;
      SrcOvf8:  return 1;
      SrcCap:   return 3;
      SrcCmpB:  return 5;
      SrcCmpA:  return 6;
      default:  return 7;
    endcase
  endfunction
endpackage

// File: rtl/timer_flag_ctrl.sv
module timer_flag_ctrl
  import timer_flag_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [CntW-1:0]   count,
  input  logic [CntW-1:0]   cmpA,
  input  logic [CntW-1:0]   cmpB,
  input  logic              captureEvt,
  input  logic              topReached,
  input  logic              capIsTop,
  input  logic              ovf16Evt,
  input  logic              ovf8Evt,
  input  logic              cmp8Evt,
  input  logic              wrEn,
  input  logic [ByteW-1:0]  wrData,
  input  logic [NumSrc-1:0] ack,
  output flagStrobe_t       strobe
);
  localparam int NumCmp = 2;

  logic [CntW-1:0]   cmpVal [NumCmp];
  logic [NumCmp-1:0] matchPend;

  assign cmpVal[0] = cmpA;
  assign cmpVal[1] = cmpB;

  // A match seen on one tick is held until the next tick, which raises the flag.
  // Forced-compare strobes are not part of this path.
  for (genvar c = 0; c < NumCmp; c++) begin : gCmp
    always_ff @(posedge clk) begin
      if (!rstN)     matchPend[c] <= 1'b0;
      else if (tick) matchPend[c] <= (count == cmpVal[c]);
    end
  end

  always_comb begin
    strobe.setVec           = '0;
    strobe.setVec[SrcCmp8]  = tick & cmp8Evt;
    strobe.setVec[SrcOvf8]  = tick & ovf8Evt;
    strobe.setVec[SrcCap]   = captureEvt | (tick & capIsTop & topReached);
    strobe.setVec[SrcCmpB]  = tick & matchPend[1];
    strobe.setVec[SrcCmpA]  = tick & matchPend[0];
    strobe.setVec[SrcOvf16] = tick & ovf16Evt;
  end

  for (genvar s = 0; s < NumSrc; s++) begin : gClr
    assign strobe.clrVec[s] = ack[s] | (wrEn & wrData[flagPos(s)]);
  end
endmodule

// File: rtl/timer_flag_dp.sv
module timer_flag_dp
  import timer_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobe,
  input  logic [NumSrc-1:0] irqEnable,
  output logic [ByteW-1:0]  flagsOut,
  output logic [NumSrc-1:0] irq
);
  logic [NumSrc-1:0] flagQ;

  for (genvar s = 0; s < NumSrc; s++) begin : gFlag
    // set has priority so a coinciding clear cannot drop an event
    always_ff @(posedge clk) begin
      if (!rstN)                  flagQ[s] <= 1'b0;
      else if (strobe.setVec[s])  flagQ[s] <= 1'b1;
      else if (strobe.clrVec[s])  flagQ[s] <= 1'b0;
    end
    assign irq[s] = flagQ[s] & irqEnable[s];
  end

  always_comb begin
    flagsOut = '0;
    for (int s = 0; s < NumSrc; s++) flagsOut[flagPos(s)] = flagQ[s];
  end
endmodule

// File: rtl/timer_flag_reg.sv
module timer_flag_reg
  import timer_flag_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [CntW-1:0]   count,
  input  logic [CntW-1:0]   cmpA,
  input  logic [CntW-1:0]   cmpB,
  input  logic              forceA,
  input  logic              forceB,
  input  logic              captureEvt,
  input  logic              topReached,
  input  logic              capIsTop,
  input  logic              ovf16Evt,
  input  logic              ovf8Evt,
  input  logic              cmp8Evt,
  input  logic              wrEn,
  input  logic [ByteW-1:0]  wrData,
  input  logic [NumSrc-1:0] ack,
  input  logic [NumSrc-1:0] irqEnable,
  output logic [ByteW-1:0]  flagsOut,
  output logic [NumSrc-1:0] irq
);
  flagStrobe_t strobe;

  timer_flag_ctrl #(.CntW(CntW)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .count(count), .cmpA(cmpA), .cmpB(cmpB),
    .captureEvt(captureEvt), .topReached(topReached), .capIsTop(capIsTop),
    .ovf16Evt(ovf16Evt), .ovf8Evt(ovf8Evt), .cmp8Evt(cmp8Evt),
    .wrEn(wrEn), .wrData(wrData), .ack(ack), .strobe(strobe)
  );

  timer_flag_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqEnable(irqEnable),
    .flagsOut(flagsOut), .irq(irq)
  );
endmodule

// File: rtl/timer_flag_chk.sv
module timer_flag_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       forceA,
  input logic       forceB,
  input logic       captureEvt,
  input logic       ovf16Evt,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [5:0] ack,
  input logic [5:0] irqEnable,
  input logic [7:0] flagsOut,
  input logic [5:0] irq
);
  assert_reset_clear_R1: assert property (@(posedge clk) !rstN |=> flagsOut == 8'h00);

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrData[4] || wrData[2])) |=> (flagsOut[4] == 1'b0 && flagsOut[2] == 1'b0));

  assert_cmpa_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagsOut[6]) |-> $past(tick));

  assert_cmpb_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagsOut[5]) |-> $past(tick));

  assert_force_no_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((forceA || forceB) && !tick) |=> (!$rose(flagsOut[6]) && !$rose(flagsOut[5])));

  assert_capture_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    captureEvt |=> flagsOut[3]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tick && ovf16Evt && (ack[5] || (wrEn && wrData[7]))) |=> flagsOut[7]);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq == ({flagsOut[7:5], flagsOut[3], flagsOut[1:0]} & irqEnable));
endmodule

bind timer_flag_reg timer_flag_chk u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .forceA(forceA), .forceB(forceB),
  .captureEvt(captureEvt), .ovf16Evt(ovf16Evt), .wrEn(wrEn), .wrData(wrData),
  .ack(ack), .irqEnable(irqEnable), .flagsOut(flagsOut), .irq(irq)
);

// File: tb/timer_flag_reg_tb.sv
`timescale 1ns/1ps
module timer_flag_reg_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] count = '0, cmpA = 16'hFFFF, cmpB = 16'hFFFF;
  logic        forceA = 1'b0, forceB = 1'b0, captureEvt = 1'b0, topReached = 1'b0;
  logic        capIsTop = 1'b0, ovf16Evt = 1'b0, ovf8Evt = 1'b0, cmp8Evt = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [5:0]  ack = '0, irqEnable = '0;
  logic [7:0]  flagsOut;
  logic [5:0]  irq;

  int checks = 0, failures = 0;
  logic [5:0] mFlag = '0;
  logic       mPendA = 1'b0, mPendB = 1'b0;

  always #2 clk = ~clk;

  timer_flag_reg u_dut (.*);

  // source index -> byte position (R1 layout)
  function automatic logic [7:0] toByte(input logic [5:0] f);
    return {f[5], f[4], f[3], 1'b0, f[2], 1'b0, f[1], f[0]};
  endfunction

  task automatic quiet();
    tick = 0; forceA = 0; forceB = 0; captureEvt = 0; topReached = 0; capIsTop = 0;
    ovf16Evt = 0; ovf8Evt = 0; cmp8Evt = 0; wrEn = 0; wrData = '0; ack = '0;
    count = '0; cmpA = 16'hFFFF; cmpB = 16'hFFFF;
  endtask

  task automatic step(input string tag);
    logic [5:0] s, c;
    s[0] = tick & cmp8Evt;
    s[1] = tick & ovf8Evt;
    s[2] = captureEvt | (tick & capIsTop & topReached);
    s[3] = tick & mPendB;
    s[4] = tick & mPendA;
    s[5] = tick & ovf16Evt;
    c = ack | (wrEn ? {wrData[7], wrData[6], wrData[5], wrData[3], wrData[1], wrData[0]} : 6'b0);
    @(posedge clk);
    if (!rstN) begin
      mFlag = '0; mPendA = 0; mPendB = 0;
    end else begin
      mFlag = (mFlag & ~c) | s;
      if (tick) begin
        mPendA = (count == cmpA);
        mPendB = (count == cmpB);
      end
    end
    #1;
    checks++;
    if (flagsOut !== toByte(mFlag)) begin
      failures++;
      $display("FAIL %s flags actual=%02h expected=%02h", tag, flagsOut, toByte(mFlag));
    end
    checks++;
    if (irq !== (mFlag & irqEnable)) begin
      failures++;
      $display("FAIL %s/R11 irq actual=%02h expected=%02h", tag, irq, mFlag & irqEnable);
    end
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    irqEnable = 6'h3F;
    repeat (3) step("R1 reset");
    rstN = 1;
    step("R1 idle");

    // R7: events without tick are ignored, with tick they set
    ovf16Evt = 1; ovf8Evt = 1; cmp8Evt = 1; step("R7 no tick");
    tick = 1; step("R7 tick");
    quiet(); step("R7 hold");

    // R8: zero write leaves, one write clears selected
    wrEn = 1; wrData = 8'h00; step("R8 write zero");
    wrData = 8'h80; step("R8 clear bit7");
    wrData = 8'hFF; step("R8 clear all");
    quiet();

    // R3: compare A match, idle cycles, then next tick sets
    tick = 1; count = 16'd5; cmpA = 16'd5; step("R3 match A");
    tick = 0; count = 16'd0; step("R3 wait A");
    step("R3 wait A2");
    tick = 1; step("R3 set A");
    quiet(); tick = 1; count = 16'h1234; cmpB = 16'h1234; step("R3 match B");
    count = 16'd0; step("R3 set B");
    quiet(); wrEn = 1; wrData = 8'h60; step("R3 clear");
    quiet();

    // R4: forced strobes with ticks and no match
    forceA = 1; forceB = 1; tick = 1; count = 16'd1; cmpA = 16'd9; cmpB = 16'd8;
    repeat (3) step("R4 force");
    quiet(); step("R4 after");

    // R5: capture without tick
    captureEvt = 1; step("R5 capture");
    quiet(); ack = 6'b000100; step("R9 ack capture");
    quiet();

    // R6: TOP reached with and without capture-as-TOP
    tick = 1; topReached = 1; capIsTop = 0; step("R6 not top mode");
    capIsTop = 1; step("R6 top mode");
    quiet();

    // R2: writes to unused bits
    wrEn = 1; wrData = 8'h14; step("R2 unused write");
    quiet();

    // R9: acknowledge each source one at a time
    tick = 1; ovf16Evt = 1; ovf8Evt = 1; cmp8Evt = 1; captureEvt = 1; step("R9 fill");
    quiet();
    for (int i = 0; i < 6; i++) begin
      ack = 6'b1 << i; step("R9 ack");
    end
    quiet();

    // R10: set and clear together
    tick = 1; ovf16Evt = 1; ack = 6'b100000; wrEn = 1; wrData = 8'h80; step("R10 set wins");
    quiet(); captureEvt = 1; ack = 6'b000100; step("R10 capture wins");
    quiet();

    // R11: mask patterns
    irqEnable = 6'b000000; step("R11 mask none");
    irqEnable = 6'b100100; step("R11 mask some");

    // random traffic over all requirements
    for (int n = 0; n < 600; n++) begin
      tick       = ($urandom % 3) != 0;
      count      = 16'($urandom % 4);
      cmpA       = 16'($urandom % 4);
      cmpB       = 16'($urandom % 4);
      forceA     = ($urandom % 4) == 0;
      forceB     = ($urandom % 4) == 0;
      captureEvt = ($urandom % 10) == 0;
      topReached = ($urandom % 5) == 0;
      capIsTop   = ($urandom % 2) == 0;
      ovf16Evt   = ($urandom % 8) == 0;
      ovf8Evt    = ($urandom % 8) == 0;
      cmp8Evt    = ($urandom % 8) == 0;
      wrEn       = ($urandom % 6) == 0;
      wrData     = 8'($urandom);
      ack        = (($urandom % 5) == 0) ? 6'(1 << ($urandom % 6)) : 6'b0;
      irqEnable  = 6'($urandom);
      step("R3/R8/R9/R10 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule